// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block keeps the pending-interrupt state of a processor subsystem together with an enable mask, and collapses the two into a single interrupt request line. Each peripheral interrupt source drives one bit of `src_i`. A high level on a source sets the matching pending bit. Software reads the pending bits and acknowledges them through a small register window on a simple memory-mapped bus.

Acknowledge uses an AND-write. Each zero in the written word clears the matching pending bit, and each one keeps it. Software can therefore clear exactly the sources it has serviced without racing against new events. Writing the enable mask replaces the whole mask. The request line follows the new mask at once, so an event that was already pending raises the request as soon as it is unmasked, with no need for a fresh source event. The direct-memory-access controller's summary interrupt is wired to source bit 3.

Both registers accept 16-bit and 32-bit accesses with the same meaning.

Top module: `isc_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, the pending register, the mask register and `irq_o` are all zero.
- R2: `src_i[k]` high at a rising clock edge sets pending bit k. Bit 3 carries the direct-memory-access summary event. A pending bit never becomes set without its source.
- R3: A write to offset 0x0 replaces the pending register with (old value AND the written value). A 0 bit clears that bit. A 1 bit leaves it as it was.
- R4: When a source is high in the same cycle as a write that clears its pending bit, the bit ends up set.
- R5: A write to offset 0x4 replaces the whole mask with the written value. Without such a write, the mask holds its value.
- R6: In every cycle, `irq_o` equals the OR over all bits of (pending AND mask) for the register values of that cycle. A mask write that exposes an already-pending bit therefore raises `irq_o` in the cycle after the write edge.
- R7: Only bits 10:0 exist. Written bits above bit 10 have no effect, and they read as zero. A 16-bit access (`wide_i`=0) uses `wdata_i[15:0]` and has the same effect on bits 10:0 as a 32-bit access (`wide_i`=1).
- R8: With `req_i`=1 and `we_i`=0, `rdata_o` combinationally returns the register selected by `addr_i`, zero-extended. For a 16-bit access, `rdata_o[31:16]` is zero. Offsets other than 0x0 and 0x4 read as zero and ignore writes. With `req_i`=0, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Byte offset within the window |
| wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| src_i | input | 11 | Interrupt source events, one per bit |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Register writes and source events take effect at the next rising edge. The bench drives inputs at the falling edge and checks the new register values at the following falling edge, one cycle later. `irq_o` is registered from the next-state values, so it is checked in that same falling-edge window against the bench model of pending AND mask. Reads are combinational, so each read is checked a short delay after its address is driven, while the clock stays low.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_MASK} reg_sel_e;
  localparam logic [2:0] STAT_OFS = 3'h0;
  localparam logic [2:0] MASK_OFS = 3'h4;
  localparam int DMA_SUMMARY_BIT = 3;
endpackage

// File: rtl/isc_bus_decode.sv
module isc_bus_decode
  import isc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter int NSRC = 11
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wide_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] stat_q_i,
  input  logic [NSRC-1:0] mask_q_i,
  output logic            wr_stat_o,
  output logic            wr_mask_o,
  output logic [NSRC-1:0] wd_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int HW = DW / 2;

  reg_sel_e sel;
  logic [DW-1:0] wd_full, rd_full;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == STAT_OFS[AW-1:0]) sel = SEL_STAT;
    else if (addr_i == MASK_OFS[AW-1:0]) sel = SEL_MASK;
  end

  assign wr_stat_o = req_i && we_i && (sel == SEL_STAT);
  assign wr_mask_o = req_i && we_i && (sel == SEL_MASK);

  // 16-bit access only carries the low half
  assign wd_full = wide_i ? wdata_i : {{(DW-HW){1'b0}}, wdata_i[HW-1:0]};
  assign wd_o    = wd_full[NSRC-1:0];

  always_comb begin
    rd_full = '0;
    if (req_i && !we_i) begin
      case (sel)
        SEL_STAT: rd_full[NSRC-1:0] = stat_q_i;
        SEL_MASK: rd_full[NSRC-1:0] = mask_q_i;
        default:  rd_full = '0;
      endcase
    end
    if (!wide_i) rd_full[DW-1:HW] = '0;
  end

  assign rdata_o = rd_full;
endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int NSRC = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wd_i,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] stat_d_o,
  output logic [NSRC-1:0] stat_q_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    logic kept;
    assign kept        = wr_i ? (stat_q_o[k] & wd_i[k]) : stat_q_o[k];
    // source wins over a same-cycle acknowledge
    assign stat_d_o[k] = src_i[k] | kept;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q_o[k] <= 1'b0;
      else         stat_q_o[k] <= stat_d_o[k];
    end
  end
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int NSRC = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wd_i,
  output logic [NSRC-1:0] mask_d_o,
  output logic [NSRC-1:0] mask_q_o
);
  assign mask_d_o = wr_i ? wd_i : mask_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q_o <= '0;
    else         mask_q_o <= mask_d_o;
  end
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen #(
  parameter int NSRC = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] stat_d_i,
  input  logic [NSRC-1:0] mask_d_i,
  output logic            irq_o
);
  // built from next-state values so irq tracks the registers without lag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_d_i & mask_d_i);
  end
endmodule

// File: rtl/isc_top.sv
module isc_top #(
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter int NSRC = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wide_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o
);
  logic            wr_stat, wr_mask;
  logic [NSRC-1:0] wd, stat_d, stat_q, mask_d, mask_q;

  isc_bus_decode #(.DW(DW), .AW(AW), .NSRC(NSRC)) u_dec (
    .req_i, .we_i, .addr_i, .wide_i, .wdata_i,
    .stat_q_i(stat_q), .mask_q_i(mask_q),
    .wr_stat_o(wr_stat), .wr_mask_o(wr_mask), .wd_o(wd), .rdata_o
  );

  isc_status_reg #(.NSRC(NSRC)) u_stat (
    .clk_i, .rst_ni, .wr_i(wr_stat), .wd_i(wd), .src_i,
    .stat_d_o(stat_d), .stat_q_o(stat_q)
  );

  isc_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk_i, .rst_ni, .wr_i(wr_mask), .wd_i(wd),
    .mask_d_o(mask_d), .mask_q_o(mask_q)
  );

  isc_irq_gen #(.NSRC(NSRC)) u_irq (
    .clk_i, .rst_ni, .stat_d_i(stat_d), .mask_d_i(mask_d), .irq_o
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int DW   = 32,
  parameter int AW   = 3,
  parameter int NSRC = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic            wide_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic [NSRC-1:0] src_i,
  input logic            irq_o,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] mask_q
);
  logic mask_wr, stat_wr;
  logic [NSRC-1:0] wlo;
  assign mask_wr = req_i && we_i && (addr_i == AW'(4));
  assign stat_wr = req_i && we_i && (addr_i == AW'(0));
  assign wlo     = wdata_i[NSRC-1:0];

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (stat_q == '0 && mask_q == '0 && !irq_o); // R1
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(stat_q & mask_q)); // R6

  AST_SRC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((stat_q & $past(src_i)) == $past(src_i))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_i)) == '0)); // R2

  AST_ACK_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wide_i) |=> (stat_q == (($past(stat_q) & $past(wlo)) | $past(src_i)))); // R3

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && wide_i) |=> (mask_q == $past(wlo))); // R5

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_q)); // R5

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NSRC] == '0); // R7
endmodule

bind isc_top isc_checker #(.DW(DW), .AW(AW), .NSRC(NSRC)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wide_i, .wdata_i, .rdata_o,
  .src_i, .irq_o, .stat_q, .mask_q
);

// File: tb/isc_top_test.sv
module isc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, wide = 1'b1;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NSRC-1:0] src = '0;
  logic irq;

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;
  logic [NSRC-1:0] e_stat = '0, e_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wide_i(wide), .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  function automatic logic [NSRC-1:0] f_wd(input logic w, input logic [31:0] d);
    logic [31:0] t;
    t = w ? d : {16'h0, d[15:0]};
    return t[NSRC-1:0];
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] a, input logic w,
                                         input logic [NSRC-1:0] s, input logic [NSRC-1:0] m);
    logic [31:0] r;
    r = '0;
    if (a == 3'h0) r[NSRC-1:0] = s;
    else if (a == 3'h4) r[NSRC-1:0] = m;
    if (!w) r[31:16] = '0;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clocked cycle; inputs driven at negedge, results checked next negedge
  task automatic op(input logic r, input logic w, input logic [2:0] a,
                    input logic wd16n, input logic [31:0] d, input logic [NSRC-1:0] s);
    logic [NSRC-1:0] wd;
    req = r; we = w; addr = a; wide = wd16n; wdata = d; src = s;
    wd = f_wd(wd16n, d);
    @(posedge clk);
    if (r && w && a == 3'h0) e_stat = e_stat & wd;
    e_stat = e_stat | s;
    if (r && w && a == 3'h4) e_mask = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0; src = '0;
    check(irq == |(e_stat & e_mask), "R6 irq", {31'h0, irq}, {31'h0, |(e_stat & e_mask)});
  endtask

  task automatic rd(input logic [2:0] a, input logic w, input string tag);
    logic [31:0] e;
    req = 1'b1; we = 1'b0; addr = a; wide = w;
    #1;
    e = f_read(a, w, e_stat, e_mask);
    check(rdata == e, tag, rdata, e);
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    rd(3'h0, 1'b1, "R1 status reset");
    rd(3'h4, 1'b1, "R1 mask reset");

    // R2: summary event on bit 3
    op(1'b0, 1'b0, 3'h0, 1'b1, 32'h0, 11'h008);
    rd(3'h0, 1'b1, "R2 bit3 set");
    op(1'b0, 1'b0, 3'h0, 1'b1, 32'h0, 11'h401);
    rd(3'h0, 1'b1, "R2 bits 0 and 10 set");
    check(irq == 1'b0, "R6 masked no irq", {31'h0, irq}, 32'h0);

    // R6: unmask a pending bit raises irq without a new event
    op(1'b1, 1'b1, 3'h4, 1'b1, 32'h0000_0008, '0);
    check(irq == 1'b1, "R6 unmask pending", {31'h0, irq}, 32'h1);
    rd(3'h4, 1'b1, "R5 mask load");

    // R3: ones keep, zeros clear
    op(1'b1, 1'b1, 3'h0, 1'b1, 32'hFFFF_FFF7, '0);
    rd(3'h0, 1'b1, "R3 clear bit3 keep others");
    check(irq == 1'b0, "R6 irq drops after ack", {31'h0, irq}, 32'h0);

    // R4: source wins over clear
    op(1'b1, 1'b1, 3'h0, 1'b1, 32'h0, 11'h008);
    rd(3'h0, 1'b1, "R4 set beats clear");

    // R7: 16-bit write ignores upper half, high bits absent
    op(1'b1, 1'b1, 3'h4, 1'b0, 32'hFFFF_0405, '0);
    rd(3'h4, 1'b1, "R7 16-bit mask write");
    op(1'b1, 1'b1, 3'h4, 1'b1, 32'hFFFF_FFFF, '0);
    rd(3'h4, 1'b1, "R7 upper bits read zero");
    rd(3'h4, 1'b0, "R8 16-bit read");

    // R8: unmapped offsets
    op(1'b1, 1'b1, 3'h2, 1'b1, 32'h0, '0);
    rd(3'h0, 1'b1, "R8 bad offset write ignored");
    rd(3'h4, 1'b1, "R8 mask unchanged by bad offset");
    rd(3'h6, 1'b1, "R8 bad offset reads zero");
    req = 1'b0; #1;
    check(rdata == 32'h0, "R8 idle rdata zero", rdata, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [NSRC-1:0] s;
      logic [31:0] sel;
      sel = $urandom_range(0, 5);
      a = (sel < 2) ? 3'h0 : (sel < 4) ? 3'h4 : (sel == 4) ? 3'h2 : 3'h6;
      s = (($urandom_range(0, 3) == 0) ? NSRC'($urandom) : '0);
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)),
         $urandom, s);
      rd(3'h0, 1'($urandom_range(0, 1)), "R3 random status");
      rd(3'h4, 1'b1, "R5 random mask");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule